// File: doc/BRIEF.md
# Byte-Lane RAM with Single-Cycle Misaligned Access

This block is a synchronous on-chip RAM behind a 16-bit data port. Each request carries a byte address, a read/write flag and a low-byte strobe. Together, the strobe and the address's least significant bit choose one of eight access kinds: an 8-bit or 16-bit read or write at an even or odd address. The block reports the kind it decoded on a 3-bit code output, so the access can be observed. Every kind finishes in one clock, including a 16-bit access that starts at an odd address.

Storage is split into two byte-wide banks. The even bank holds even byte addresses and always uses the high half of the bus. The odd bank holds odd byte addresses and always uses the low half. Each bank has its own row address. A misaligned 16-bit access therefore reaches odd-bank row N and even-bank row N+1 in the same cycle. On the bus, the addressed byte is in the low half and the following byte is in the high half, which is the reverse of the aligned order. Each bank has its own write enable, so an 8-bit write changes only the byte it addresses. Read data is registered. It appears one clock after the request and holds until the next read.

Top module: `lane_ram_top`

## Requirements
- R1: `access_code` is `{wide, odd, write}` for any request. `wide` is 1 when `lstrobe` equals `addr[0]`, `odd` equals `addr[0]`, and `write` equals `!rw`. The eight values are: 000 8-bit even read, 001 8-bit even write, 010 8-bit odd read, 011 8-bit odd write, 100 aligned 16-bit read, 101 aligned 16-bit write, 110 misaligned 16-bit read, 111 misaligned 16-bit write.
- R2: An 8-bit access at an even address (`lstrobe`=1, `addr[0]`=0) moves the byte on `wdata[15:8]` / `rdata[15:8]`, and the read returns `rdata[7:0]` = 0.
- R3: An 8-bit access at an odd address (`lstrobe`=0, `addr[0]`=1) moves the byte on `wdata[7:0]` / `rdata[7:0]`, and the read returns `rdata[15:8]` = 0.
- R4: An aligned 16-bit access (`lstrobe`=0, `addr[0]`=0) puts byte A on bits 15:8 and byte A+1 on bits 7:0.
- R5: A misaligned 16-bit access (`lstrobe`=1, `addr[0]`=1) completes in one request cycle, with byte A on bits 7:0 and byte A+1 on bits 15:8.
- R6: An 8-bit write leaves the other byte of the same 16-bit row unchanged.
- R7: A misaligned 16-bit access at the highest byte address takes location 0 as its second byte.
- R8: `rdata` is 0 after reset. It takes a read's result on the clock edge that follows the request, and it keeps its value through cycles that carry no read.
- R9: A cycle with `req` low writes nothing, whatever `rw`, `addr` and `wdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request this cycle |
| rw | input | 1 | 1 = read, 0 = write |
| lstrobe | input | 1 | Low-byte strobe; selects the access width together with addr[0] |
| addr | input | ADDR_W | Byte address |
| wdata | input | 16 | Write data, high lane bits 15:8 |
| rdata | output | 16 | Registered read data |
| access_code | output | 3 | Decoded access kind {wide, odd, write} |

## Verification
The bench builds the block with ADDR_W = 5, which gives 32 bytes in two 16-row banks. At that size it can visit every byte address with both strobe values, for both reads and writes, and so covers all eight access kinds at every location. It also reaches the top-of-memory wrap without a long run. Accesses follow one another back-to-back with mixed widths. Each read result is compared with a byte-array model in the cycle after its request, while the next request is already being driven.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;

    localparam int LANE_W = 8;
    localparam int BUS_W  = 2 * LANE_W;
    localparam int LANES  = BUS_W / LANE_W;

    // Lane index 1 = even bank (bus bits 15:8), lane 0 = odd bank (bits 7:0)
    localparam int EVEN_LANE = 1;
    localparam int ODD_LANE  = 0;

    // Code layout {wide, odd, write}
    typedef enum logic [2:0] {
        ACC_RD8_EVEN  = 3'b000,
        ACC_WR8_EVEN  = 3'b001,
        ACC_RD8_ODD   = 3'b010,
        ACC_WR8_ODD   = 3'b011,
        ACC_RD16_ALN  = 3'b100,
        ACC_WR16_ALN  = 3'b101,
        ACC_RD16_MIS  = 3'b110,
        ACC_WR16_MIS  = 3'b111
    } access_kind_e;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [LANE_W-1:0] wdata;
    } bank_cmd_t;

    function automatic access_kind_e classify(input logic strobe,
                                              input logic a0,
                                              input logic rd);
        logic [2:0] code;
        code[2] = (strobe == a0);
        code[1] = a0;
        code[0] = ~rd;
        return access_kind_e'(code);
    endfunction

    function automatic logic kind_is_wide(input access_kind_e k);
        return k[2];
    endfunction

    function automatic logic kind_is_misaligned(input access_kind_e k);
        return k[2] & k[1];
    endfunction

    function automatic logic kind_is_write(input access_kind_e k);
        return k[0];
    endfunction

    // Which bank lanes an access kind touches
    function automatic logic [LANES-1:0] kind_lanes(input access_kind_e k);
        logic [LANES-1:0] m;
        if (kind_is_wide(k)) begin
            m = '1;
        end else begin
            m = '0;
            if (k[1]) m[ODD_LANE]  = 1'b1;
            else      m[EVEN_LANE] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lane_ram_decode.sv
module lane_ram_decode
    import lane_ram_pkg::*;
#(
    parameter int ROW_W = 9
) (
    input  logic                              req,
    input  logic                              rw,
    input  logic                              strobe,
    input  logic [ROW_W:0]                    addr,
    input  logic [BUS_W-1:0]                  wdata,
    output access_kind_e                      kind,
    output logic [LANES-1:0]                  lanes,
    output logic [LANES-1:0][ROW_W-1:0]       rows,
    output bank_cmd_t [LANES-1:0]             cmds
);

    localparam logic [ROW_W-1:0] ROW_STEP = 1;

    logic [ROW_W-1:0] base_row;

    always_comb begin
        kind     = classify(strobe, addr[0], rw);
        lanes    = kind_lanes(kind);
        base_row = addr[ROW_W:1];
    end

    // Odd bank always uses the addressed row; even bank advances one row
    // for a misaligned access, wrapping at the top through the row width.
    always_comb begin
        rows[ODD_LANE]  = base_row;
        rows[EVEN_LANE] = kind_is_misaligned(kind) ? base_row + ROW_STEP : base_row;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_cmd
        always_comb begin
            cmds[g].en    = req & lanes[g];
            cmds[g].we    = req & lanes[g] & kind_is_write(kind);
            cmds[g].wdata = wdata[g*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/lane_ram_bank.sv
module lane_ram_bank
    import lane_ram_pkg::*;
#(
    parameter int ROW_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_cmd_t         cmd,
    input  logic [ROW_W-1:0]  row,
    output logic [LANE_W-1:0] dout
);

    localparam int ROWS = 1 << ROW_W;

    logic [LANE_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (cmd.en && cmd.we) begin
            mem[row] <= cmd.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (cmd.en && !cmd.we) begin
            dout <= mem[row];
        end
    end

endmodule

// File: rtl/lane_ram_top.sv
module lane_ram_top
    import lane_ram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              rw,
    input  logic              lstrobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [2:0]        access_code
);

    localparam int ROW_W = ADDR_W - 1;
    localparam logic [ROW_W-1:0] ROW_ONE = 1;

    access_kind_e                  kind;
    logic [LANES-1:0]              lanes;
    logic [LANES-1:0][ROW_W-1:0]   rows;
    bank_cmd_t [LANES-1:0]         cmds;
    logic [LANES-1:0][LANE_W-1:0]  bank_out;
    logic [LANES-1:0]              live_q;

    lane_ram_decode #(.ROW_W(ROW_W)) u_decode (
        .req    (req),
        .rw     (rw),
        .strobe (lstrobe),
        .addr   (addr),
        .wdata  (wdata),
        .kind   (kind),
        .lanes  (lanes),
        .rows   (rows),
        .cmds   (cmds)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        lane_ram_bank #(.ROW_W(ROW_W)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .cmd  (cmds[g]),
            .row  (rows[g]),
            .dout (bank_out[g])
        );
    end

    // Remember which lanes the last read filled; others read back as zero
    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else if (req && rw) begin
            live_q <= lanes;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign rdata[g*LANE_W +: LANE_W] = live_q[g] ? bank_out[g] : '0;
    end

    assign access_code = kind;

    // ---------------- assertions ----------------
    assert_wide_code_R1: assert property (@(posedge clk) disable iff (rst)
        (lstrobe == addr[0]) |-> access_code[2]);

    assert_even8_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (req && rw && lstrobe && !addr[0]) |=> (rdata[7:0] == 8'h00));

    assert_odd8_high_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (req && rw && !lstrobe && addr[0]) |=> (rdata[15:8] == 8'h00));

    assert_mis_rows_R5: assert property (@(posedge clk) disable iff (rst)
        (req && lstrobe && addr[0]) |->
        (rows[EVEN_LANE] == rows[ODD_LANE] + ROW_ONE) && cmds[0].en && cmds[1].en);

    assert_even8_write_alone_R6: assert property (@(posedge clk) disable iff (rst)
        (req && !rw && lstrobe && !addr[0]) |-> !cmds[ODD_LANE].we);

    assert_odd8_write_alone_R6: assert property (@(posedge clk) disable iff (rst)
        (req && !rw && !lstrobe && addr[0]) |-> !cmds[EVEN_LANE].we);

    assert_top_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (req && lstrobe && (&addr)) |-> (rows[EVEN_LANE] == '0));

    assert_hold_rdata_R8: assert property (@(posedge clk) disable iff (rst)
        !(req && rw) |=> $stable(rdata));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req |-> !(cmds[0].en || cmds[1].en));

endmodule

// File: tb/tb_lane_ram_top.sv
module tb_lane_ram_top;

    localparam int AW    = 5;
    localparam int BYTES = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          rw = 1'b1;
    logic          lstrobe = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [2:0]    access_code;

    lane_ram_top #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .req(req), .rw(rw), .lstrobe(lstrobe),
        .addr(addr), .wdata(wdata), .rdata(rdata), .access_code(access_code)
    );

    always #5 clk = ~clk;

    logic [7:0] model [BYTES];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    pend   = 0;
    logic [15:0] pexp = '0;
    string ptag   = "";
    logic [15:0] last = '0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_read(input bit s, input logic [AW-1:0] a);
        logic [AW-1:0] n;
        n = a + 1'b1;
        if (s && !a[0])      return {model[a], 8'h00};
        else if (!s && a[0]) return {8'h00, model[a]};
        else if (!s)         return {model[a], model[n]};
        else                 return {model[n], model[a]};
    endfunction

    task automatic model_write(input bit s, input logic [AW-1:0] a, input logic [15:0] wd);
        logic [AW-1:0] n;
        n = a + 1'b1;
        if (s && !a[0])      model[a] = wd[15:8];
        else if (!s && a[0]) model[a] = wd[7:0];
        else if (!s) begin   model[a] = wd[15:8]; model[n] = wd[7:0]; end
        else begin           model[a] = wd[7:0];  model[n] = wd[15:8]; end
    endtask

    function automatic string read_tag(input bit s, input logic [AW-1:0] a);
        if (s && !a[0])      return "R2";
        else if (!s && a[0]) return "R3";
        else if (!s)         return "R4";
        else if (&a)         return "R7";
        else                 return "R5";
    endfunction

    // One cycle: check the previous cycle's result, then drive this one
    task automatic acc(input bit en, input bit s, input logic [AW-1:0] a,
                       input bit rd, input logic [15:0] wd, input string tag);
        @(negedge clk);
        if (pend) check(ptag, rdata, pexp);
        else      check("R8", rdata, last);
        pend = 0;
        req = en; lstrobe = s; addr = a; rw = rd; wdata = wd;
        #1;
        if (en) check("R1", {13'h0, access_code},
                      {13'h0, (s == a[0]), a[0], ~rd});
        if (en && rd) begin
            pexp = expect_read(s, a);
            ptag = (tag == "") ? read_tag(s, a) : tag;
            pend = 1;
            last = pexp;
        end else if (en) begin
            model_write(s, a, wd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", rdata, 16'h0000);
        rst = 1'b0;

        // fill memory with aligned writes
        for (int r = 0; r < BYTES / 2; r++)
            acc(1, 0, AW'(2 * r), 0, {8'(14 * r + 3), 8'(14 * r + 10)}, "");

        // read every byte address in both strobe settings
        for (int a = 0; a < BYTES; a++)
            for (int s = 0; s < 2; s++)
                acc(1, s[0], AW'(a), 1, 16'h0, "");

        // writes of every kind, each followed by readback around it
        for (int a = 0; a < BYTES; a++)
            for (int s = 0; s < 2; s++) begin
                acc(1, s[0], AW'(a), 0, 16'(a * 37 + s * 91 + 5) ^ 16'hA5C3, "");
                acc(1, 0, AW'(a & ~1), 1, 16'h0, "R6");
                acc(1, 0, AW'((a + 2) & ~1), 1, 16'h0, "R6");
                acc(1, s[0], AW'(a), 1, 16'h0, "");
            end

        // idle and write cycles must not disturb rdata
        acc(1, 1, AW'(9), 1, 16'h0, "");
        acc(0, 0, AW'(0), 1, 16'h0, "");
        acc(1, 0, AW'(12), 0, 16'h1234, "");
        acc(0, 0, AW'(0), 1, 16'h0, "");

        // request low: nothing written
        acc(0, 0, AW'(4), 0, 16'hFFFF, "");
        acc(0, 1, AW'(7), 0, 16'hEEEE, "");
        acc(1, 0, AW'(4), 1, 16'h0, "R9");
        acc(1, 0, AW'(6), 1, 16'h0, "R9");

        // explicit wrap at the top
        acc(1, 1, AW'(BYTES - 1), 0, 16'hBEEF, "");
        acc(1, 0, AW'(0), 1, 16'h0, "R7");
        acc(1, 0, AW'(BYTES - 2), 1, 16'h0, "R7");
        acc(1, 1, AW'(BYTES - 1), 1, 16'h0, "R7");

        // misaligned mid-memory, back-to-back with 8-bit accesses
        acc(1, 1, AW'(13), 0, 16'hC0DE, "");
        acc(1, 1, AW'(14), 1, 16'h0, "R2");
        acc(1, 0, AW'(13), 1, 16'h0, "R3");
        acc(1, 1, AW'(13), 1, 16'h0, "R5");
        acc(0, 0, AW'(0), 1, 16'h0, "");
        acc(0, 0, AW'(0), 1, 16'h0, "");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule